// File: doc/BRIEF.md
# Audio Serial Port Clock Master

This block generates the bit clock and the left/right frame clock of a converter's serial audio port from the master clock (MCLK). The block itself runs on MCLK with a synchronous, active-high reset. In master mode it drives both lines and asserts an output enable for each one. In slave mode it drops both enables and holds its own drivers low, so the pins can act as inputs.

A 3-bit frame-ratio code sets how many MCLK cycles make one frame clock period. A 3-bit bit-rate code sets the bit clock. Some bit-rate codes pick a fixed fraction of MCLK. The others pick a number of bit clocks per frame, so the bit divider is worked out from both codes together. When a combination cannot be built with a whole divider of at least 2, the bit clock is held low and an error flag is raised.

The controller is a four-state machine:
- `ST_SLAVE`: lines released.
- `ST_ALIGN`: one cycle after any change of the mode or a code, with both dividers restarted.
- `ST_RUN`: normal output.
- `ST_FAULT`: running, but with an unbuildable bit clock.

The transitions are:
- slave→align when master mode is selected.
- align→run, or align→fault, on the validity of the codes.
- run/fault/align→align on a code change while in master mode.
- any→slave when slave mode is selected.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is held, and after it is released with the inputs at zero, both clock outputs, both enables and `cfg_err` are low.
- R2: When `master_sel`=0 (slave), `bclk_oe` and `lrclk_oe` are 0, and `bclk_o`, `lrclk_o` and `cfg_err` are 0.
- R3: When `master_sel`=1 (master), both enables are 1 from the clock edge that samples the select.
- R4: The frame period in MCLK cycles follows `fs_code`: 001=128, 010=192, 011=256, 100=384, 101=512, 110=768.
- R5: `fs_code` 000 (auto detect) and 111 (reserved) both use a frame period of 256 MCLK cycles.
- R6: `bk_code` 000 gives a bit period of 4 MCLK cycles, and 001 gives 8 MCLK cycles, whatever the frame period.
- R7: `bk_code` 010, 011 and 100 give 32, 64 and 128 bit periods per frame, so the bit period is the frame period divided by that count.
- R8: `bk_code` 101, 110 and 111 behave as 64 bit periods per frame.
- R9: If a per-frame bit code gives a quotient that is not a whole number, or is below 2, then `bclk_o` stays low and `cfg_err` is 1 while in master mode. The frame clock keeps running.
- R10: Within each bit period of D MCLK cycles, `bclk_o` is low for the first D−⌊D/2⌋ cycles and high for the last ⌊D/2⌋ cycles.
- R11: `lrclk_o` is low for the first half of each frame and high for the second half. It changes only on the same edge where `bclk_o` falls.
- R12: On the edge that samples a changed `master_sel`, `fs_code` or `bk_code`, both dividers restart. Both clock outputs read 0 after that edge, and counting resumes from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| master_sel | input | 1 | 1 = drive the clocks, 0 = release them |
| fs_code | input | 3 | MCLK cycles per frame selection |
| bk_code | input | 3 | Bit clock rate selection |
| bclk_o | output | 1 | Bit clock drive value |
| bclk_oe | output | 1 | Bit clock output enable |
| lrclk_o | output | 1 | Frame clock drive value |
| lrclk_oe | output | 1 | Frame clock output enable |
| cfg_err | output | 1 | Code pair cannot form a bit clock |

## Verification
The bench builds the block with its default counter width of 10 bits. That width holds the longest frame of 768 MCLK cycles, so every entry of both code tables can be reached, including the error pairs: 128 MCLK per frame with 128 bits, and 192 MCLK per frame with 128 bits. Odd bit periods (3 MCLK at 192 per frame with 64 bits) exercise the uneven duty cycle. Code changes in the middle of a frame exercise the restart path.

// File: rtl/acg_pkg.sv
package acg_pkg;

    parameter int ACG_CNT_W = 10;

    typedef enum logic [1:0] {
        ST_SLAVE,
        ST_ALIGN,
        ST_RUN,
        ST_FAULT
    } acg_state_e;

    typedef struct packed {
        logic       master;
        logic [2:0] fs_code;
        logic [2:0] bk_code;
    } acg_cfg_t;

endpackage

// File: rtl/acg_rate_decode.sv
module acg_rate_decode #(
    parameter int CNT_W = 10
) (
    input  logic [2:0]       fs_code,
    input  logic [2:0]       bk_code,
    output logic [CNT_W-1:0] frame_div,
    output logic [CNT_W-1:0] bit_div,
    output logic             bad
);
    logic [CNT_W-1:0] fixed_div;
    logic [CNT_W-1:0] quo;
    logic [CNT_W-1:0] rem;
    logic [2:0]       shift;
    logic             per_frame;

    always_comb begin
        unique case (fs_code)
            3'b001:  frame_div = CNT_W'(128);
            3'b010:  frame_div = CNT_W'(192);
            3'b011:  frame_div = CNT_W'(256);
            3'b100:  frame_div = CNT_W'(384);
            3'b101:  frame_div = CNT_W'(512);
            3'b110:  frame_div = CNT_W'(768);
            default: frame_div = CNT_W'(256);
        endcase
    end

    always_comb begin
        per_frame = 1'b1;
        fixed_div = CNT_W'(4);
        shift     = 3'd6;
        unique case (bk_code)
            3'b000: begin per_frame = 1'b0; fixed_div = CNT_W'(4); end
            3'b001: begin per_frame = 1'b0; fixed_div = CNT_W'(8); end
            3'b010: shift = 3'd5;
            3'b011: shift = 3'd6;
            3'b100: shift = 3'd7;
            default: shift = 3'd6;
        endcase
    end

    always_comb begin
        quo     = frame_div >> shift;
        rem     = frame_div & ((CNT_W'(1) << shift) - CNT_W'(1));
        bit_div = per_frame ? quo : fixed_div;
        bad     = per_frame && ((rem != '0) || (quo < CNT_W'(2)));
    end

endmodule

// File: rtl/acg_div_counter.sv
module acg_div_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic [W-1:0] nxt
);
    always_comb begin
        if (clear)
            nxt = '0;
        else if (cnt >= limit - W'(1))
            nxt = '0;
        else
            nxt = cnt + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= nxt;
    end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import acg_pkg::*;
#(
    parameter int CNT_W = ACG_CNT_W
) (
    input  logic       mclk,
    input  logic       rst,
    input  logic       master_sel,
    input  logic [2:0] fs_code,
    input  logic [2:0] bk_code,
    output logic       bclk_o,
    output logic       bclk_oe,
    output logic       lrclk_o,
    output logic       lrclk_oe,
    output logic       cfg_err
);
    localparam int HALF_W = CNT_W;

    acg_state_e       state_q, state_n;
    acg_cfg_t         cfg_q, cfg_cur;
    logic             changed;
    logic             clear;
    logic [CNT_W-1:0] frame_div, bit_div;
    logic             bad;
    logic [CNT_W-1:0] bcnt, bnxt, fcnt, fnxt;
    logic [HALF_W-1:0] bit_low;
    logic [HALF_W-1:0] frame_half;
    logic             bclk_d, lrclk_d, oe_d, err_d;

    assign cfg_cur = '{master: master_sel, fs_code: fs_code, bk_code: bk_code};
    assign changed = (cfg_cur != cfg_q);

    acg_rate_decode #(.CNT_W(CNT_W)) u_decode (
        .fs_code   (fs_code),
        .bk_code   (bk_code),
        .frame_div (frame_div),
        .bit_div   (bit_div),
        .bad       (bad)
    );

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_SLAVE: begin
                if (changed && master_sel) state_n = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (!master_sel)  state_n = ST_SLAVE;
                else if (changed) state_n = ST_ALIGN;
                else if (bad)     state_n = ST_FAULT;
                else              state_n = ST_RUN;
            end
            ST_RUN, ST_FAULT: begin
                if (!master_sel)  state_n = ST_SLAVE;
                else if (changed) state_n = ST_ALIGN;
            end
            default: state_n = ST_SLAVE;
        endcase
    end

    assign clear = changed || (state_n == ST_SLAVE);

    acg_div_counter #(.W(CNT_W)) u_bit_cnt (
        .clk   (mclk),
        .rst   (rst),
        .clear (clear),
        .limit (bit_div),
        .cnt   (bcnt),
        .nxt   (bnxt)
    );

    acg_div_counter #(.W(CNT_W)) u_frame_cnt (
        .clk   (mclk),
        .rst   (rst),
        .clear (clear),
        .limit (frame_div),
        .cnt   (fcnt),
        .nxt   (fnxt)
    );

    assign bit_low    = bit_div - (bit_div >> 1);
    assign frame_half = frame_div >> 1;

    // Output decode per next state
    always_comb begin
        bclk_d  = 1'b0;
        lrclk_d = 1'b0;
        oe_d    = 1'b0;
        err_d   = 1'b0;
        unique case (state_n)
            ST_SLAVE: begin
                oe_d = 1'b0;
            end
            ST_ALIGN, ST_RUN: begin
                oe_d    = 1'b1;
                err_d   = bad;
                bclk_d  = !bad && (bnxt >= bit_low);
                lrclk_d = (fnxt >= frame_half);
            end
            ST_FAULT: begin
                oe_d    = 1'b1;
                err_d   = 1'b1;
                lrclk_d = (fnxt >= frame_half);
            end
            default: oe_d = 1'b0;
        endcase
    end

    // State and configuration register
    always_ff @(posedge mclk) begin
        if (rst) begin
            state_q <= ST_SLAVE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_n;
            cfg_q   <= cfg_cur;
        end
    end

    // Output register
    always_ff @(posedge mclk) begin
        if (rst) begin
            bclk_o   <= 1'b0;
            lrclk_o  <= 1'b0;
            bclk_oe  <= 1'b0;
            lrclk_oe <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            bclk_o   <= bclk_d;
            lrclk_o  <= lrclk_d;
            bclk_oe  <= oe_d;
            lrclk_oe <= oe_d;
            cfg_err  <= err_d;
        end
    end

endmodule

// File: rtl/acg_checker.sv
module acg_checker (
    input logic       mclk,
    input logic       rst,
    input logic       master_sel,
    input logic [2:0] fs_code,
    input logic [2:0] bk_code,
    input logic       bclk_o,
    input logic       bclk_oe,
    input logic       lrclk_o,
    input logic       lrclk_oe,
    input logic       cfg_err
);
    assert_released_R2: assert property (@(posedge mclk) disable iff (rst)
        !bclk_oe |-> (!bclk_o && !lrclk_o && !cfg_err));

    assert_oe_pair_R3: assert property (@(posedge mclk) disable iff (rst)
        bclk_oe == lrclk_oe);

    assert_oe_on_R3: assert property (@(posedge mclk) disable iff (rst)
        master_sel |=> bclk_oe);

    assert_oe_off_R2: assert property (@(posedge mclk) disable iff (rst)
        !master_sel |=> !bclk_oe);

    assert_fault_low_R9: assert property (@(posedge mclk) disable iff (rst)
        cfg_err |-> !bclk_o);

    assert_lr_on_fall_R11: assert property (@(posedge mclk) disable iff (rst)
        ($rose(lrclk_o) && !cfg_err) |-> $fell(bclk_o));

    assert_restart_R12: assert property (@(posedge mclk) disable iff (rst)
        ({master_sel, fs_code, bk_code} != $past({master_sel, fs_code, bk_code}))
        |=> (!bclk_o && !lrclk_o));
endmodule

bind audio_clkgen acg_checker u_acg_checker (
    .mclk       (mclk),
    .rst        (rst),
    .master_sel (master_sel),
    .fs_code    (fs_code),
    .bk_code    (bk_code),
    .bclk_o     (bclk_o),
    .bclk_oe    (bclk_oe),
    .lrclk_o    (lrclk_o),
    .lrclk_oe   (lrclk_oe),
    .cfg_err    (cfg_err)
);

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;

    logic       mclk = 1'b0;
    logic       rst = 1'b1;
    logic       master_sel = 1'b0;
    logic [2:0] fs_code = 3'b000;
    logic [2:0] bk_code = 3'b000;
    logic       bclk_o, bclk_oe, lrclk_o, lrclk_oe, cfg_err;

    int n_run = 0;
    int n_fail = 0;
    int j = 0;
    logic [6:0] prev_cfg = 7'd0;

    always #4 mclk = ~mclk;

    audio_clkgen i_audio_clkgen (
        .mclk       (mclk),
        .rst        (rst),
        .master_sel (master_sel),
        .fs_code    (fs_code),
        .bk_code    (bk_code),
        .bclk_o     (bclk_o),
        .bclk_oe    (bclk_oe),
        .lrclk_o    (lrclk_o),
        .lrclk_oe   (lrclk_oe),
        .cfg_err    (cfg_err)
    );

    function automatic int frame_len(input logic [2:0] f);
        case (f)
            3'd1: return 128;
            3'd2: return 192;
            3'd3: return 256;
            3'd4: return 384;
            3'd5: return 512;
            3'd6: return 768;
            default: return 256;
        endcase
    endfunction

    function automatic int bits_per_frame(input logic [2:0] b);
        case (b)
            3'd2: return 32;
            3'd3: return 64;
            3'd4: return 128;
            default: return 64;
        endcase
    endfunction

    function automatic int bit_len(input logic [2:0] f, input logic [2:0] b);
        if (b == 3'd0) return 4;
        if (b == 3'd1) return 8;
        return frame_len(f) / bits_per_frame(b);
    endfunction

    function automatic bit is_bad(input logic [2:0] f, input logic [2:0] b);
        int n;
        if (b < 3'd2) return 1'b0;
        n = bits_per_frame(b);
        return ((frame_len(f) % n) != 0) || ((frame_len(f) / n) < 2);
    endfunction

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    task automatic run_cfg(input logic m, input logic [2:0] f, input logic [2:0] b, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            logic e_b, e_l, e_oe, e_err, bad;
            int d, fl;
            string tb_tag, tl_tag;
            master_sel = m; fs_code = f; bk_code = b;
            @(posedge mclk);
            @(negedge mclk);
            if ({m, f, b} != prev_cfg) begin
                j = 0;
                prev_cfg = {m, f, b};
            end else begin
                j++;
            end
            bad = is_bad(f, b);
            fl  = frame_len(f);
            d   = bit_len(f, b);
            e_oe  = m;
            e_err = m && bad;
            e_l   = m && ((j % fl) >= fl / 2);
            e_b   = m && !bad && ((j % d) >= (d - d / 2));
            if (j == 0)        begin tb_tag = "R12"; tl_tag = "R12"; end
            else if (!m)       begin tb_tag = "R2";  tl_tag = "R2"; end
            else begin
                if (bad)           tb_tag = "R9";
                else if (b < 3'd2) tb_tag = "R6 R10";
                else if (b < 3'd5) tb_tag = "R7 R10";
                else               tb_tag = "R8 R10";
                tl_tag = (f == 3'd0 || f == 3'd7) ? "R5 R11" : "R4 R11";
            end
            check(tb_tag, "bclk_o", bclk_o, e_b);
            check(tl_tag, "lrclk_o", lrclk_o, e_l);
            check(m ? "R3" : "R2", "oe", bclk_oe & lrclk_oe | (bclk_oe ^ lrclk_oe), e_oe);
            check("R9", "cfg_err", cfg_err, e_err);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge mclk);
        check("R1", "bclk_o in reset", bclk_o, 1'b0);
        check("R1", "lrclk_o in reset", lrclk_o, 1'b0);
        check("R1", "oe in reset", bclk_oe | lrclk_oe, 1'b0);
        check("R1", "cfg_err in reset", cfg_err, 1'b0);
        rst = 1'b0;
        run_cfg(1'b0, 3'd0, 3'd0, 4);
        // directed corners
        run_cfg(1'b1, 3'd3, 3'd3, 600);   // 256 MCLK, 64 bits
        run_cfg(1'b1, 3'd2, 3'd3, 500);   // odd bit period 3
        run_cfg(1'b1, 3'd1, 3'd4, 300);   // quotient 1: error
        run_cfg(1'b1, 3'd2, 3'd4, 450);   // non-integer: error
        run_cfg(1'b1, 3'd6, 3'd1, 1600);  // 768, MCLK/8
        run_cfg(1'b1, 3'd0, 3'd0, 600);   // auto detect fallback
        run_cfg(1'b1, 3'd7, 3'd6, 600);   // reserved both
        run_cfg(1'b1, 3'd5, 3'd2, 7);     // short, then change mid-frame
        run_cfg(1'b1, 3'd5, 3'd7, 1100);
        run_cfg(1'b0, 3'd5, 3'd7, 20);    // released
        run_cfg(1'b0, 3'd4, 3'd2, 20);
        run_cfg(1'b1, 3'd4, 3'd4, 900);   // 384/128 = 3
        for (int s = 0; s < 30; s++) begin
            logic m;
            logic [2:0] f, b;
            int len;
            m = (($urandom % 4) != 0);
            f = 3'($urandom % 8);
            b = 3'($urandom % 8);
            len = (($urandom % 5) == 0) ? int'($urandom % 40) + 1
                                        : 2 * frame_len(f) + int'($urandom % 64);
            run_cfg(m, f, b, len);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule